// File: doc/BRIEF.md
# Asymmetric Half-Bridge Chopping Mapper

This block drives the two transistors of one phase leg in an asymmetric half-bridge from a single unsigned duty code. The code is bipolar in meaning. Zero requests the full negative link voltage on average and the top code requests the full positive voltage. Three ways of switching the leg are available. In hard chopping both transistors switch together. In soft chopping one transistor is parked for the whole period and the other one chops. In complementary chopping both transistors chop at the base rate with their on-windows half a period apart, so the phase voltage ripple runs at twice the switching rate.

For soft chopping the top bit of the code picks the polarity. When it is set, the upper transistor is held on. When it is clear, the upper transistor is held off. In both cases the remaining bits, shifted up by one, set the chopping duty of the lower transistor. The block runs its own sawtooth carrier. The duty code and the mode are captured once per carrier period, at the wrap. The phase enable acts at once, so that a disabled phase loses both gates on the next edge.

Top module: `chop_mapper`

## Requirements
- R1: While `rst` is high, both gate outputs are low and the carrier is held at zero. The carrier counts one step per clock and wraps after P = 2^DUTY_W cycles.
- R2: On the first clock edge at which `phase_en` is sampled low, both gates go low. They stay low for as long as the enable stays low.
- R3: In hard mode (`mode_sel` = 0), both gates are identical in every cycle. Each is high for exactly D cycles of every period, where D is the captured duty code.
- R4: In soft mode (`mode_sel` = 1) with the duty MSB set, the upper gate is high for the whole period. The lower gate is high for 2*(D - P/2) cycles.
- R5: In soft mode with the duty MSB clear, the upper gate is low for the whole period. The lower gate is high for 2*D cycles.
- R6: In complementary mode (`mode_sel` = 2), each gate is high for D cycles per period. The lower gate's on-window is offset from the upper gate's by P/2 cycles. Both gates are high together for max(0, 2D-P) cycles of each period.
- R7: In complementary mode, each gate has exactly one rising edge per period when D > 0, and none when D = 0.
- R8: A change of `duty_cmd` or `mode_sel` has no effect on the gates before the carrier wraps. It takes effect from the first cycle of the next period.
- R9: The unused mode code (`mode_sel` = 3) behaves exactly as hard mode. This keeps a safe hard-chopping fallback, for example for braking.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| duty_cmd | input | DUTY_W | Bipolar duty code (0 = full negative, top = full positive) |
| mode_sel | input | 2 | 0 hard, 1 soft, 2 complementary, 3 treated as hard |
| phase_en | input | 1 | Phase enable; low forces both gates off |
| gate_hi | output | 1 | Upper transistor gate (registered) |
| gate_lo | output | 1 | Lower transistor gate (registered) |

## Verification
A carrier that steps wrongly or wraps early shows up at once as wrong per-period on-counts for the gates. A wrong half-period offset makes the overlap count wrong in complementary mode within one period. A command register that latches at the wrong moment changes the gates in the same period the input was changed, so the mid-period change tests expose it before the next wrap. A stale or mis-decoded mode shows within one period as a held gate that chops, or as gates that stop matching in hard mode.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    CH_HARD = 2'd0,
    CH_SOFT = 2'd1,
    CH_COMP = 2'd2
  } chop_mode_e;

  // Raw select to operating mode; the spare code falls back to hard chopping.
  function automatic chop_mode_e decode_mode(input logic [1:0] sel);
    case (sel)
      2'd1:    decode_mode = CH_SOFT;
      2'd2:    decode_mode = CH_COMP;
      default: decode_mode = CH_HARD;
    endcase
  endfunction

endpackage

// File: rtl/chop_carrier.sv
module chop_carrier #(
  parameter int DUTY_W = 8,
  parameter int N_TAPS = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  output logic [N_TAPS-1:0][DUTY_W-1:0] carr,
  output logic                          period_end
);
  localparam logic [DUTY_W-1:0] CNT_MAX = {DUTY_W{1'b1}};
  localparam int                TAP_STEP = (1 << DUTY_W) / N_TAPS;

  logic [DUTY_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  assign period_end = (cnt == CNT_MAX);

  // Each tap is the base carrier advanced by an equal fraction of the period.
  genvar k;
  generate
    for (k = 0; k < N_TAPS; k++) begin : g_tap
      assign carr[k] = cnt + DUTY_W'(k * TAP_STEP);
    end
  endgenerate

  AST_CARRIER_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (cnt == DUTY_W'($past(cnt) + 1'b1))); // R1

endmodule

// File: rtl/chop_cmd_latch.sv
module chop_cmd_latch
  import chop_pkg::*;
#(
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              period_end,
  input  logic [DUTY_W-1:0] duty_cmd,
  input  logic [1:0]        mode_sel,
  output logic [DUTY_W-1:0] duty_q,
  output chop_mode_e        mode_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      duty_q <= '0;
      mode_q <= CH_HARD;
    end else if (period_end) begin
      duty_q <= duty_cmd;
      mode_q <= decode_mode(mode_sel);
    end
  end
endmodule

// File: rtl/chop_gate_logic.sv
module chop_gate_logic
  import chop_pkg::*;
#(
  parameter int DUTY_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0][DUTY_W-1:0] carr,
  input  logic [DUTY_W-1:0]      duty_q,
  input  chop_mode_e             mode_q,
  input  logic                   phase_en,
  output logic                   gate_hi,
  output logic                   gate_lo
);
  localparam int N_CMP = 2;

  logic              polarity;
  logic [DUTY_W-1:0] chop_duty;
  logic [DUTY_W-1:0] ref_duty;
  logic [N_CMP-1:0]  hit;
  logic              nxt_hi, nxt_lo;

  // Polarity bit picks the parked transistor; the rest doubled is the chop duty.
  assign polarity  = duty_q[DUTY_W-1];
  assign chop_duty = {duty_q[DUTY_W-2:0], 1'b0};
  assign ref_duty  = (mode_q == CH_SOFT) ? chop_duty : duty_q;

  genvar k;
  generate
    for (k = 0; k < N_CMP; k++) begin : g_cmp
      assign hit[k] = (carr[k] < ref_duty);
    end
  endgenerate

  always_comb begin
    case (mode_q)
      CH_SOFT: begin
        nxt_hi = polarity;
        nxt_lo = hit[0];
      end
      CH_COMP: begin
        nxt_hi = hit[0];
        nxt_lo = hit[1];
      end
      default: begin
        nxt_hi = hit[0];
        nxt_lo = hit[0];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !phase_en) begin
      gate_hi <= 1'b0;
      gate_lo <= 1'b0;
    end else begin
      gate_hi <= nxt_hi;
      gate_lo <= nxt_lo;
    end
  end

  AST_DISABLED_OFF: assert property (@(posedge clk) disable iff (rst)
    !$past(phase_en) |-> (!gate_hi && !gate_lo)); // R2

  AST_HARD_TIED: assert property (@(posedge clk) disable iff (rst)
    $past(mode_q == CH_HARD) |-> (gate_hi == gate_lo)); // R3

  AST_SOFT_POS_UPPER: assert property (@(posedge clk) disable iff (rst)
    $past(mode_q == CH_SOFT && polarity && phase_en) |-> gate_hi); // R4

  AST_SOFT_NEG_UPPER: assert property (@(posedge clk) disable iff (rst)
    $past(mode_q == CH_SOFT && !polarity) |-> !gate_hi); // R5

endmodule

// File: rtl/chop_mapper.sv
module chop_mapper
  import chop_pkg::*;
#(
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DUTY_W-1:0] duty_cmd,
  input  logic [1:0]        mode_sel,
  input  logic              phase_en,
  output logic              gate_hi,
  output logic              gate_lo
);
  logic [1:0][DUTY_W-1:0] carr;
  logic                   period_end;
  logic [DUTY_W-1:0]      duty_q;
  chop_mode_e             mode_q;

  chop_carrier #(.DUTY_W(DUTY_W), .N_TAPS(2)) u_carrier (
    .clk        (clk),
    .rst        (rst),
    .carr       (carr),
    .period_end (period_end)
  );

  chop_cmd_latch #(.DUTY_W(DUTY_W)) u_latch (
    .clk        (clk),
    .rst        (rst),
    .period_end (period_end),
    .duty_cmd   (duty_cmd),
    .mode_sel   (mode_sel),
    .duty_q     (duty_q),
    .mode_q     (mode_q)
  );

  chop_gate_logic #(.DUTY_W(DUTY_W)) u_gates (
    .clk      (clk),
    .rst      (rst),
    .carr     (carr),
    .duty_q   (duty_q),
    .mode_q   (mode_q),
    .phase_en (phase_en),
    .gate_hi  (gate_hi),
    .gate_lo  (gate_lo)
  );

  AST_CMD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    ((duty_q != $past(duty_q)) || (mode_q != $past(mode_q))) |-> (carr[0] == '0)); // R8

endmodule

// File: tb/tb_chop_mapper.sv
module tb_chop_mapper;
  localparam int W = 6;
  localparam int P = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] duty_cmd = '0;
  logic [1:0]   mode_sel = 2'd0;
  logic         phase_en = 1'b0;
  logic         gate_hi, gate_lo;

  int checks = 0;
  int fails  = 0;
  int tb_cyc = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  chop_mapper #(.DUTY_W(W)) dut (
    .clk(clk), .rst(rst), .duty_cmd(duty_cmd), .mode_sel(mode_sel),
    .phase_en(phase_en), .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  // Edge counter: after edge n the gates show carrier value (n-1) mod P.
  always @(posedge clk) begin
    if (rst) tb_cyc <= 0;
    else     tb_cyc <= tb_cyc + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_phase(input int ph);
    do @(negedge clk); while ((tb_cyc % P) != ph);
  endtask

  task automatic measure(output int nhi, output int nlo, output int nboth,
                         output int rhi, output int rlo);
    logic phi, plo;
    nhi = 0; nlo = 0; nboth = 0; rhi = 0; rlo = 0;
    @(negedge clk);
    phi = gate_hi; plo = gate_lo;
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      nhi   += int'(gate_hi);
      nlo   += int'(gate_lo);
      nboth += int'(gate_hi && gate_lo);
      if (gate_hi && !phi) rhi++;
      if (gate_lo && !plo) rlo++;
      phi = gate_hi; plo = gate_lo;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int nhi, nlo, nboth, rhi, rlo;
    int ehi, elo, eboth, chop;
    string tag;

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 gate_hi in reset", int'(gate_hi), 0);
    check("R1 gate_lo in reset", int'(gate_lo), 0);
    phase_en = 1'b1;
    rst = 1'b0;

    // Sweep of every mode code and every duty code
    for (int m = 0; m < 4; m++) begin
      for (int d = 0; d < P; d++) begin
        @(negedge clk);
        mode_sel = 2'(m);
        duty_cmd = W'(d);
        repeat (P + 3) @(negedge clk);
        measure(nhi, nlo, nboth, rhi, rlo);
        if (m == 1) begin
          chop = 2 * (d % (P / 2));
          if (d >= P / 2) begin tag = "R4"; ehi = P; elo = chop; eboth = chop; end
          else            begin tag = "R5"; ehi = 0; elo = chop; eboth = 0;    end
        end else if (m == 2) begin
          tag = "R6"; ehi = d; elo = d; eboth = (2 * d > P) ? 2 * d - P : 0;
          check("R7 upper rises per period", rhi, (d > 0) ? 1 : 0);
          check("R7 lower rises per period", rlo, (d > 0) ? 1 : 0);
        end else begin
          tag = (m == 3) ? "R9" : "R3";
          ehi = d; elo = d; eboth = d;
        end
        check($sformatf("%s upper on-count m=%0d d=%0d", tag, m, d), nhi, ehi);
        check($sformatf("%s lower on-count m=%0d d=%0d", tag, m, d), nlo, elo);
        check($sformatf("%s overlap count m=%0d d=%0d", tag, m, d), nboth, eboth);
      end
    end

    // R8: duty change mid-period waits for the wrap (hard, P/2 -> P-1)
    @(negedge clk); mode_sel = 2'd0; duty_cmd = W'(P / 2);
    repeat (2 * P) @(negedge clk);
    wait_phase(P / 2 + 4);
    duty_cmd = W'(P - 1);
    do begin
      check("R8 upper keeps old duty before wrap", int'(gate_hi), 0);
      @(negedge clk);
    end while ((tb_cyc % P) != 1);
    check("R8 upper takes new duty after wrap", int'(gate_hi), 1);

    // R8: mode change mid-period (soft P/2 -> hard P/2)
    @(negedge clk); mode_sel = 2'd1; duty_cmd = W'(P / 2);
    repeat (2 * P) @(negedge clk);
    wait_phase(P / 2 + 6);
    mode_sel = 2'd0;
    do begin
      check("R8 lower keeps old mode before wrap", int'(gate_lo), 0);
      check("R8 upper keeps old mode before wrap", int'(gate_hi), 1);
      @(negedge clk);
    end while ((tb_cyc % P) != 1);
    check("R8 lower takes new mode after wrap", int'(gate_lo), 1);

    // R2: disable forces both gates off on the next edge
    @(negedge clk); mode_sel = 2'd1; duty_cmd = W'(P - 1);
    repeat (2 * P) @(negedge clk);
    phase_en = 1'b0;
    @(negedge clk);
    check("R2 upper off after disable", int'(gate_hi), 0);
    check("R2 lower off after disable", int'(gate_lo), 0);
    measure(nhi, nlo, nboth, rhi, rlo);
    check("R2 upper stays off", nhi, 0);
    check("R2 lower stays off", nlo, 0);
    phase_en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R2 upper back on after enable", int'(gate_hi), 1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule